// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block steps one DMA channel through a chain of tasks held in a table in memory. There are two four-word control structures. The primary structure sits at `PRI_BASE` and the alternate structure at `ALT_BASE`. Each structure holds a source pointer, a destination pointer, a control word and one spare word. The primary structure works as a loader. Each time it runs, it copies the next four-word descriptor out of the table into the alternate slot. The sequencer then carries out the task that the freshly loaded alternate structure describes. After that it returns to the primary structure, and this repeats until the chain ends.

The two chaining modes differ in how they request arbitration. In memory-driven chaining, the block raises its own request before each step. In peripheral-driven chaining, each step waits for the peripheral request line, but the descriptor load always runs straight into the task it loaded, with no arbitration between the two. Every structure is kept in memory. The block reads the structure back after each grant and writes it back after each burst, so a structure whose count is used up is left marked invalid. A chain ends quietly when the block reads an invalid structure. It ends with a one-cycle `done` pulse when an alternate task of the basic type completes.

Top module: `sg_chain_seq`

## Requirements
- R1: The cycle type sits in control bits [2:0]. Code 3'b100 starts a memory-driven chain and 3'b110 starts a peripheral-driven chain. Any other code in the primary structure ends the sequence with no transfer and no write.
- R2: A structure is laid out as +0 source pointer, +4 destination pointer and +8 control word. For the alternate structure, code 3'b001 means basic, 3'b101 means a memory chain step, 3'b111 means a peripheral chain step, and 3'b000 means invalid. The primary structure's destination word is ignored; its copy always lands at `ALT_BASE` and onward.
- R3: A primary step copies four words from its source pointer to `ALT_BASE`..`ALT_BASE+12`. It then writes back the source pointer advanced by 16 bytes and the count field decremented by four.
- R4: The channel starts from a `start` pulse. While `arb_req` is high there is no memory access. The cycle after a grant begins a read of the structure.
- R5: A burst moves min(2^P, N+1) words. P is the power field in bits [17:14] and N is the remaining-minus-one count in bits [13:4]. An increment code of 2'b11 (source in bits [27:26], destination in bits [31:30]) holds the pointer; any other code advances it by 4 bytes. The pointers and the count are written back after every burst.
- R6: In a peripheral-driven chain, the alternate structure is read in the cycle right after the primary write-back, with no arbitration in between. Every later arbitration waits for `periph_req`.
- R7: In a memory-driven chain, the block requests arbitration by itself after each descriptor load, between bursts, and after each chained task.
- R8: `done` goes high for exactly one cycle after the control write-back of a completed basic alternate task.
- R9: When a burst uses up a structure's count, the control word is written back with type 3'b000 and a count of zero.
- R10: Reading an invalid alternate structure ends the chain without `done`. A completed chain-step task returns to the primary structure, and an exhausted table then ends the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a chain when the block is idle |
| periph_req | input | 1 | Peripheral request used to arbitrate in a peripheral-driven chain |
| arb_req | output | 1 | Arbitration request |
| arb_gnt | input | 1 | Grant; the handshake completes when it is high together with `arb_req` |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the read strobe |
| done | output | 1 | Completion pulse of a basic task |

## Verification
A wrong decode of the control word shows up within a few cycles of a grant. The block either stops issuing memory traffic or writes to unexpected addresses, and both are caught when memory is compared against a transaction-level model. A wrong burst count or pointer register corrupts the table or the data area at the next write-back, and this stays visible in memory until the end of the run. A wrong mode flag shows up as an arbitration handshake in the gap between the primary write-back and the alternate read, or as a missing handshake there. The grant count per chain and the gap monitor catch this on the first descriptor load.

// File: rtl/sg_chain_seq.sv
module sg_chain_seq #(
  parameter int AW       = 16,
  parameter int PRI_BASE = 'h000,
  parameter int ALT_BASE = 'h010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          periph_req,
  output logic          arb_req,
  input  logic          arb_gnt,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          done
);
  localparam logic [AW-1:0] PRI_A = AW'(PRI_BASE);
  localparam logic [AW-1:0] ALT_A = AW'(ALT_BASE);
  localparam int CW = 10;
  localparam logic [2:0] CT_OFF = 3'b000, CT_BASIC = 3'b001;
  localparam logic [2:0] CT_MPRI = 3'b100, CT_MALT = 3'b101;
  localparam logic [2:0] CT_PPRI = 3'b110, CT_PALT = 3'b111;

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_LOAD, S_RD, S_WR, S_SAVE} st_t;

  st_t           st;
  logic          alt_q, pmode_q, auto_q, fin_q, done_q;
  logic [1:0]    idx;
  logic [AW-1:0] src_q, dst_q;
  logic [31:0]   ctrl_q;
  logic [CW-1:0] cnt_q;

  wire [AW-1:0] base  = alt_q ? ALT_A : PRI_A;
  wire [AW-1:0] slot  = base + AW'({idx, 2'b00});
  wire [2:0]    kind  = ctrl_q[2:0];
  wire [2:0]    nkind = mem_rdata[2:0];
  wire [3:0]    npow  = mem_rdata[17:14];
  wire [CW-1:0] nleft = mem_rdata[13:4];
  wire [CW-1:0] cap   = (npow >= 4'd10) ? {CW{1'b1}} : CW'((11'd1 << npow) - 11'd1);
  wire kind_ok = alt_q ? (nkind == CT_BASIC || nkind == CT_MALT || nkind == CT_PALT)
                       : (nkind == CT_MPRI || nkind == CT_PPRI);
  wire [AW-1:0] sstep = (ctrl_q[27:26] == 2'b11) ? '0 : AW'(4);
  wire [AW-1:0] dstep = (ctrl_q[31:30] == 2'b11) ? '0 : AW'(4);
  wire wb_last = (st == S_SAVE) && (idx == 2'd2);

  assign arb_req = (st == S_ARB) && (auto_q || periph_req);
  assign mem_en  = (st == S_LOAD && idx != 2'd3) || st == S_RD || st == S_WR || st == S_SAVE;
  assign mem_we  = (st == S_WR) || (st == S_SAVE);
  assign done    = done_q;

  always_comb begin
    case (st)
      S_RD:    mem_addr = src_q;
      S_WR:    mem_addr = dst_q;
      default: mem_addr = slot;
    endcase
  end

  always_comb begin
    if (st == S_WR) mem_wdata = mem_rdata;
    else begin
      case (idx)
        2'd0:    mem_wdata = 32'(src_q);
        2'd1:    mem_wdata = 32'(dst_q);
        default: mem_wdata = {ctrl_q[31:3], fin_q ? CT_OFF : kind};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      alt_q <= 1'b0; pmode_q <= 1'b0; auto_q <= 1'b0; fin_q <= 1'b0; done_q <= 1'b0;
      idx <= '0; src_q <= '0; dst_q <= '0; ctrl_q <= '0; cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_ARB; alt_q <= 1'b0; auto_q <= 1'b1;
        end
        S_ARB: if (arb_req && arb_gnt) begin
          st <= S_LOAD; idx <= '0;
        end
        S_LOAD: begin
          idx <= idx + 2'd1;
          case (idx)
            2'd0: fin_q <= 1'b0;
            2'd1: src_q <= mem_rdata[AW-1:0];
            2'd2: dst_q <= mem_rdata[AW-1:0];
            default: begin
              ctrl_q <= mem_rdata;
              cnt_q  <= (nleft < cap) ? nleft : cap;
              if (!alt_q) begin
                pmode_q <= (nkind == CT_PPRI);
                dst_q   <= ALT_A;
              end
              st <= kind_ok ? S_RD : S_IDLE;
            end
          endcase
        end
        S_RD: st <= S_WR;
        S_WR: begin
          src_q <= src_q + sstep;
          dst_q <= dst_q + dstep;
          if (ctrl_q[13:4] == '0) fin_q <= 1'b1;
          else ctrl_q[13:4] <= ctrl_q[13:4] - 1'b1;
          if (cnt_q == '0) begin
            st <= S_SAVE; idx <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1; st <= S_RD;
          end
        end
        S_SAVE: begin
          if (!wb_last) idx <= (idx == 2'd0 && !alt_q) ? 2'd2 : idx + 2'd1;
          else if (!alt_q) begin
            alt_q <= 1'b1;
            if (pmode_q) begin st <= S_LOAD; idx <= '0; end
            else begin st <= S_ARB; auto_q <= 1'b1; end
          end else if (!fin_q) begin
            st <= S_ARB; auto_q <= !pmode_q;
          end else if (kind == CT_BASIC) begin
            st <= S_IDLE; done_q <= 1'b1;
          end else begin
            st <= S_ARB; alt_q <= 1'b0; auto_q <= !pmode_q;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_chain_seq_chk.sv
module sg_chain_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic arb_req,
  input logic arb_gnt,
  input logic mem_en,
  input logic mem_we,
  input logic done,
  input logic wb_last,
  input logic alt_q,
  input logic pmode_q
);
  AST_ARB_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n) arb_req |-> !mem_en); // R4
  AST_GRANT_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (arb_req && arb_gnt) |=> (mem_en && !mem_we)); // R4
  AST_PERIPH_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) (wb_last && !alt_q && pmode_q) |=> (mem_en && !mem_we && !arb_req)); // R6
  AST_MEM_AUTO_REQ: assert property (@(posedge clk) disable iff (!rst_n) (wb_last && !alt_q && !pmode_q) |=> arb_req); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(mem_en && mem_we)); // R8
endmodule

bind sg_chain_seq sg_chain_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arb_req(arb_req), .arb_gnt(arb_gnt),
  .mem_en(mem_en), .mem_we(mem_we), .done(done),
  .wb_last(wb_last), .alt_q(alt_q), .pmode_q(pmode_q)
);

// File: tb/sg_chain_seq_test.sv
module sg_chain_seq_test;
  localparam int AW  = 12;
  localparam int PRI = 'h000;
  localparam int ALT = 'h010;
  localparam int TBL = 'h040;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, periph_req = 1'b0, arb_gnt = 1'b0;
  logic arb_req, mem_en, mem_we, done;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  sg_chain_seq #(.AW(AW), .PRI_BASE(PRI), .ALT_BASE(ALT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .periph_req(periph_req),
    .arb_req(arb_req), .arb_gnt(arb_gnt), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done));

  always #2 clk = ~clk;

  logic [31:0] mem [1024];
  logic [31:0] em  [1024];
  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    else if (mem_en) mem_rdata <= mem[mem_addr[11:2]];
  end

  int nchk = 0, nfail = 0, cyc = 0;
  int grants, dones, gaps, pulse_err;
  bit pm_drv = 0, chain_open = 0, done_prev = 0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1 periph_req = pm_drv ? 1'($urandom % 2) : 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(0, "watchdog", "cycles", cyc, 190000);
      summary();
      $finish;
    end
    if (mem_en && mem_we && mem_addr == AW'(PRI + 8)) chain_open = 1;
    if (mem_en && !mem_we && mem_addr == AW'(ALT)) chain_open = 0;
    if (done) begin
      dones++;
      if (done_prev) pulse_err++;
    end
    done_prev = done;
    arb_gnt = arb_req && ($urandom % 3 == 0);
    if (arb_gnt) begin
      grants++;
      if (chain_open) gaps++;
    end
  end

  function automatic logic [31:0] mk(logic [1:0] di, logic [1:0] si, logic [3:0] r,
                                     logic [9:0] n, logic [2:0] t);
    return {di, 2'b10, si, 2'b10, 6'b0, r, n, 1'b0, t};
  endfunction

  function automatic logic [31:0] em_rd(int a);
    return em[(a & 'hFFF) >> 2];
  endfunction

  task automatic em_wr(int a, logic [31:0] v);
    em[(a & 'hFFF) >> 2] = v;
  endtask

  task automatic m_burst(int base, bit is_pri, output bit fin);
    logic [31:0] c;
    int s, d, n, cp, b;
    s = int'(em_rd(base) & 'hFFF);
    d = is_pri ? ALT : int'(em_rd(base + 4) & 'hFFF);
    c = em_rd(base + 8);
    n = int'(c[13:4]);
    cp = (c[17:14] >= 10) ? 1024 : (1 << c[17:14]);
    b = (n + 1 < cp) ? n + 1 : cp;
    for (int k = 0; k < b; k++) begin
      em_wr(d, em_rd(s));
      s = (s + ((c[27:26] == 2'b11) ? 0 : 4)) & 'hFFF;
      d = (d + ((c[31:30] == 2'b11) ? 0 : 4)) & 'hFFF;
    end
    fin = (b == n + 1);
    n = fin ? 0 : n - b;
    c[13:4] = 10'(n);
    if (fin) c[2:0] = 3'b000;
    em_wr(base, 32'(s));
    if (!is_pri) em_wr(base + 4, 32'(d));
    em_wr(base + 8, c);
  endtask

  task automatic model(output int g, output int dn, output int pl);
    logic [31:0] c;
    bit quit, f, pm;
    g = 1; dn = 0; pl = 0; quit = 0;
    while (!quit) begin
      c = em_rd(PRI + 8);
      if (c[2:0] != 3'b100 && c[2:0] != 3'b110) break;
      pm = (c[2:0] == 3'b110);
      m_burst(PRI, 1, f);
      pl++;
      if (!pm) g++;
      while (1) begin
        c = em_rd(ALT + 8);
        if (!(c[2:0] == 3'b001 || c[2:0] == 3'b101 || c[2:0] == 3'b111)) begin
          quit = 1; break;
        end
        m_burst(ALT, 0, f);
        if (!f) begin g++; continue; end
        if (c[2:0] == 3'b001) begin dn++; quit = 1; end
        else g++;
        break;
      end
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
  endtask

  task automatic set_pri(int ntask, bit pm);
    mem[PRI >> 2]       = TBL;
    mem[(PRI >> 2) + 1] = 32'h0;
    mem[(PRI >> 2) + 2] = mk(2'b10, 2'b10, 4'd2, 10'(4 * ntask - 1), pm ? 3'b110 : 3'b100);
  endtask

  task automatic set_task(int i, int len, int r, logic [1:0] si, logic [2:0] t);
    int a = (TBL >> 2) + 4 * i;
    mem[a]     = 'h200 + 'h80 * i;
    mem[a + 1] = 'h600 + 'h80 * i;
    mem[a + 2] = mk(2'b10, si, 4'(r), 10'(len - 1), t);
  endtask

  task automatic run_case(string rq, bit pm);
    int eg, ed, epl, q, bad;
    for (int i = 0; i < 1024; i++) em[i] = mem[i];
    model(eg, ed, epl);
    @(negedge clk);
    grants = 0; dones = 0; gaps = 0; pulse_err = 0; chain_open = 0;
    pm_drv = pm;
    start = 1;
    @(negedge clk);
    start = 0;
    q = 0;
    while (q < 40) begin
      @(negedge clk);
      if (mem_en || arb_req) q = 0; else q++;
    end
    pm_drv = 0;
    bad = -1;
    for (int i = 0; i < 1024; i++) if (bad < 0 && mem[i] !== em[i]) bad = i;
    chk(bad < 0, rq, "memory image", bad < 0 ? 0 : int'(mem[bad]), bad < 0 ? 0 : int'(em[bad]));
    chk(grants == eg, "R7", "arbitration handshakes", grants, eg);
    chk(gaps == (pm ? 0 : epl), "R6", "grants between load and task", gaps, pm ? 0 : epl);
    chk(dones == ed, "R8 R10", "done pulses", dones, ed);
    chk(pulse_err == 0, "R8", "done wider than one cycle", pulse_err, 0);
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk);
    chk(arb_req == 0, "R4", "arb_req in reset", int'(arb_req), 0);
    chk(mem_en == 0, "R4", "mem_en in reset", int'(mem_en), 0);
    chk(done == 0, "R8", "done in reset", int'(done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(arb_req == 0 && mem_en == 0, "R4", "idle before start", int'({arb_req, mem_en}), 0);

    // memory chain: bursted chain step then basic task (R3 R5 R7)
    fill(); set_pri(2, 0);
    set_task(0, 3, 1, 2'b10, 3'b101); set_task(1, 5, 3, 2'b10, 3'b001);
    run_case("R3 R5", 0);
    // peripheral chain, three tasks, source hold on last (R6 R2)
    fill(); set_pri(3, 1);
    set_task(0, 4, 2, 2'b10, 3'b111); set_task(1, 1, 0, 2'b10, 3'b111);
    set_task(2, 6, 1, 2'b11, 3'b001);
    run_case("R2 R6", 1);
    // invalid primary type (R1)
    fill(); set_pri(1, 0); mem[(PRI >> 2) + 2][2:0] = 3'b000;
    set_task(0, 2, 1, 2'b10, 3'b001);
    run_case("R1", 0);
    // basic code in primary slot is not a chain start (R1)
    fill(); set_pri(1, 0); mem[(PRI >> 2) + 2][2:0] = 3'b001;
    set_task(0, 2, 1, 2'b10, 3'b001);
    run_case("R1", 0);
    // loaded alternate is invalid (R10 R9)
    fill(); set_pri(1, 0); set_task(0, 3, 1, 2'b10, 3'b000);
    run_case("R9 R10", 0);
    // table runs out through chain steps only (R10 R9)
    fill(); set_pri(2, 1);
    set_task(0, 2, 0, 2'b10, 3'b111); set_task(1, 3, 2, 2'b10, 3'b111);
    run_case("R9 R10", 1);

    for (int it = 0; it < 20; it++) begin
      int nt = 1 + ($urandom % 3);
      bit pm = 1'($urandom % 2);
      fill(); set_pri(nt, pm);
      for (int i = 0; i < nt; i++) begin
        logic [2:0] t = pm ? 3'b111 : 3'b101;
        if (i == nt - 1 && ($urandom % 4 != 0)) t = 3'b001;
        set_task(i, 1 + ($urandom % 6), $urandom % 4, ($urandom % 4 == 0) ? 2'b11 : 2'b10, t);
      end
      run_case("R3 R5 R9", pm);
    end
    summary();
    $finish;
  end
endmodule